// File: doc/BRIEF.md
# Register-Programmed Single-Lane SPI Word Master

This block is a single-lane SPI master that software runs through a small 32-bit register file. A command register holds the clock mode, which chip select to use, whether software drives that chip select directly, the transmit and receive enables, and the word length as bits minus one. Writing the command register with its start bit set shifts one word of 1 to 32 bits, most significant bit first. Transmit words come from a four-entry TX FIFO behind a write port, and received words go into a four-entry RX FIFO behind a read port.

When a word is done, the engine sets a ready flag that software clears by writing 1. A FIFO-status register shows full and empty flags for both FIFOs, four sticky error flags with a summary bit, and two flush controls that clear themselves. Software clears the error flags by reading the status register and writing the same value back. The serial clock is the system clock divided by `2*HALF_DIV`. Its idle level and its sampling edges follow the clock-polarity and clock-phase bits of the mode field.

Register offsets: command `0x000`, transfer status `0x010`, FIFO status `0x014`, TX port `0x108`, RX port `0x188`. Reads have no side effect, with one exception: a read of the RX port pops the RX FIFO.

Top module: `spi_word_master`

## Requirements
- R1: The command register keeps start at bit 31, master at 30, mode at 29:28 (bit 29 is clock polarity, bit 28 is clock phase), chip-select index at 27:26, software chip-select enable at 21, software chip-select level at 20, receive enable at 12, transmit enable at 11 and length-minus-one at 4:0. The other bits are stored nowhere and read 0. The start bit always reads 0.
- R2: A field value L shifts exactly L+1 bits, most significant bit first, so 7 gives 8 bits and 31 gives 32 bits. Each bit makes one leading edge and one trailing edge of the serial clock.
- R3: When no word is shifting, the serial clock rests at the polarity bit. Data is sampled on leading edges when the phase bit is 0 and on trailing edges when it is 1. Data changes on the opposite edges.
- R4: With software chip-select control off, only the indexed active-low chip select goes low, and only while a word is shifting. The others stay high.
- R5: With software chip-select control on, the indexed chip select follows the level bit: 0 drives it low and 1 releases it.
- R6: Bit 30 of the transfer-status register is set when a word finishes. Writing 1 to it clears it.
- R7: Writing 1 to FIFO-status bit 15 (RX) or bit 14 (TX) empties that FIFO. The bit reads 1 on the following cycle and then clears itself.
- R8: A write to the TX port while the TX FIFO is full drops the data and sets the sticky TX-overflow flag (bit 7).
- R9: Starting a word with transmit enabled and the TX FIFO empty sets the TX-underrun flag (bit 6) and shifts out zeros.
- R10: Reading the RX port while the RX FIFO is empty returns 0 and sets the RX-underrun flag (bit 4).
- R11: With receive enabled, the received word, right-justified, is pushed into the RX FIFO at the end of the word. If the FIFO is full the word is dropped and RX overflow (bit 5) is set. With receive disabled nothing is pushed.
- R12: Bit 8 is set whenever any of bits 7:4 is set. Writing 1 to any of bits 7:4 clears that flag. Bit 8 clears only once all four are clear.
- R13: A start request made while a word is shifting is ignored and pops nothing from the TX FIFO.
- R14: FIFO-status bits 3, 2, 1 and 0 are TX full, TX empty, RX full and RX empty. Each FIFO holds four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the RX FIFO at the RX port) |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The properties assume one register access per cycle. They also assume that software does not change the clock-polarity bit in the same cycle as a start request, because that would make the idle level jump as the word begins. The stimulus always writes a new mode alone and waits a few cycles before the start write. The only time the command register is rewritten during a word is the busy-start case, and that write carries the same fields. The serial input is looped back from the serial output. Received data therefore checks the sampling edge, while a bench-side edge monitor checks the output bit order, the edge count and the chip-select level on every leading edge.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int unsigned ADDR_W = 9;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CMD   = 9'h000;
    localparam logic [ADDR_W-1:0] OFF_XSTAT = 9'h010;
    localparam logic [ADDR_W-1:0] OFF_FSTAT = 9'h014;
    localparam logic [ADDR_W-1:0] OFF_TXD   = 9'h108;
    localparam logic [ADDR_W-1:0] OFF_RXD   = 9'h188;

    // command field positions
    localparam int unsigned B_GO     = 31;
    localparam int unsigned B_MASTER = 30;
    localparam int unsigned B_MODE   = 28;
    localparam int unsigned B_CSSEL  = 26;
    localparam int unsigned B_CSSW   = 21;
    localparam int unsigned B_CSVAL  = 20;
    localparam int unsigned B_RXEN   = 12;
    localparam int unsigned B_TXEN   = 11;

    // status field positions
    localparam int unsigned B_READY   = 30;
    localparam int unsigned B_RXFLUSH = 15;
    localparam int unsigned B_TXFLUSH = 14;
    localparam int unsigned B_ERR     = 8;
    localparam int unsigned B_TXOVF   = 7;
    localparam int unsigned B_TXUNR   = 6;
    localparam int unsigned B_RXOVF   = 5;
    localparam int unsigned B_RXUNR   = 4;

    typedef struct packed {
        logic       master;
        logic [1:0] mode;
        logic [1:0] cs_sel;
        logic       cs_sw;
        logic       cs_val;
        logic       rx_en;
        logic       tx_en;
        logic [4:0] len_m1;
    } cmd_t;

    typedef struct packed {
        logic tx_ovf;
        logic tx_unr;
        logic rx_ovf;
        logic rx_unr;
    } err_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;

    function automatic cmd_t cmd_unpack(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.master = w[B_MASTER];
        c.mode   = w[B_MODE+1:B_MODE];
        c.cs_sel = w[B_CSSEL+1:B_CSSEL];
        c.cs_sw  = w[B_CSSW];
        c.cs_val = w[B_CSVAL];
        c.rx_en  = w[B_RXEN];
        c.tx_en  = w[B_TXEN];
        c.len_m1 = w[4:0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cmd_pack(input cmd_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_MASTER]             = c.master;
        w[B_MODE+1:B_MODE]      = c.mode;
        w[B_CSSEL+1:B_CSSEL]    = c.cs_sel;
        w[B_CSSW]               = c.cs_sw;
        w[B_CSVAL]              = c.cs_val;
        w[B_RXEN]               = c.rx_en;
        w[B_TXEN]               = c.tx_en;
        w[4:0]                  = c.len_m1;
        return w;
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !rst && !flush) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/spim_shift.sv
module spim_shift
    import spim_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cpol_idle,
    input  logic [1:0]        mode,
    input  logic [4:0]        len_m1,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    eng_state_t        state;
    logic [DW-1:0]     div_cnt;
    logic [6:0]        edge_cnt;
    logic [6:0]        edge_nxt;
    logic [6:0]        last_edge;
    logic [4:0]        len_l;
    logic              cpha_l;
    logic              sclk_q, done_q;
    logic [DATA_W-1:0] txs, rxs;
    logic              tick, leading, sample_now, shift_now;

    assign tick       = (div_cnt == DW'(HALF_DIV - 1));
    assign edge_nxt   = edge_cnt + 7'd1;
    assign last_edge  = {1'b0, len_l, 1'b0} + 7'd2;
    assign leading    = edge_nxt[0];
    assign sample_now = leading ^ cpha_l;
    assign shift_now  = !sample_now && !(cpha_l && edge_nxt == 7'd1)
                        && (edge_nxt != last_edge);

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            state    <= ENG_IDLE;
            sclk_q   <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            len_l    <= '0;
            cpha_l   <= 1'b0;
            txs      <= '0;
            rxs      <= '0;
        end else if (state == ENG_IDLE) begin
            sclk_q <= cpol_idle;
            if (start) begin
                state    <= ENG_RUN;
                sclk_q   <= mode[1];
                cpha_l   <= mode[0];
                len_l    <= len_m1;
                txs      <= tx_word << (5'd31 - len_m1);
                rxs      <= '0;
                div_cnt  <= '0;
                edge_cnt <= '0;
            end
        end else begin
            if (tick) begin
                div_cnt  <= '0;
                sclk_q   <= ~sclk_q;
                edge_cnt <= edge_nxt;
                if (sample_now) rxs <= {rxs[DATA_W-2:0], miso};
                if (shift_now)  txs <= {txs[DATA_W-2:0], 1'b0};
                if (edge_nxt == last_edge) begin
                    state  <= ENG_IDLE;
                    done_q <= 1'b1;
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = txs[DATA_W-1];
    assign busy    = (state == ENG_RUN);
    assign done    = done_q;
    assign rx_word = rxs;

endmodule

// File: rtl/spim_csgen.sv
module spim_csgen #(
    parameter int NUM_CS = 4
) (
    input  logic [1:0]        sel,
    input  logic              sw_en,
    input  logic              sw_level,
    input  logic              busy,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = (sel == 2'(i)) ? (sw_en ? sw_level : ~busy) : 1'b1;
    end

endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
    import spim_pkg::*;
#(
    parameter int NUM_CS     = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int HALF_DIV   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [8:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    cmd_t              cmd_q;
    err_t              err_q;
    logic              ready_q, start_q, rx_en_l;
    logic              flush_tx_q, flush_rx_q;
    logic              wr_cmd, wr_xstat, wr_fstat, wr_txd, rd_rxd;
    logic              go_req;
    logic              eng_busy, eng_done;
    logic [DATA_W-1:0] eng_rx, eng_tx;
    logic [DATA_W-1:0] tx_head, rx_head;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_pop, rx_push, rx_pop;
    err_t              err_set, err_clr;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata;

    assign wr_cmd   = reg_wr && (reg_addr == OFF_CMD);
    assign wr_xstat = reg_wr && (reg_addr == OFF_XSTAT);
    assign wr_fstat = reg_wr && (reg_addr == OFF_FSTAT);
    assign wr_txd   = reg_wr && (reg_addr == OFF_TXD);
    assign rd_rxd   = reg_rd && (reg_addr == OFF_RXD);

    assign go_req  = wr_cmd && reg_wdata[B_GO] && !eng_busy && !start_q;
    assign tx_pop  = start_q && cmd_q.tx_en && !tx_empty;
    assign eng_tx  = (cmd_q.tx_en && !tx_empty) ? tx_head : '0;
    assign rx_push = eng_done && rx_en_l;
    assign rx_pop  = rd_rxd && !rx_empty;

    assign err_set.tx_ovf = wr_txd && tx_full;
    assign err_set.tx_unr = start_q && cmd_q.tx_en && tx_empty;
    assign err_set.rx_ovf = rx_push && rx_full;
    assign err_set.rx_unr = rd_rxd && rx_empty;
    assign err_clr = wr_fstat ? err_t'(reg_wdata[B_TXOVF:B_RXUNR]) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= '0;
            err_q      <= '0;
            ready_q    <= 1'b0;
            start_q    <= 1'b0;
            rx_en_l    <= 1'b0;
            flush_tx_q <= 1'b0;
            flush_rx_q <= 1'b0;
        end else begin
            if (wr_cmd) cmd_q <= cmd_unpack(reg_wdata);
            start_q <= go_req;
            if (start_q) rx_en_l <= cmd_q.rx_en;
            err_q      <= (err_q & ~err_clr) | err_set;
            flush_tx_q <= wr_fstat && reg_wdata[B_TXFLUSH];
            flush_rx_q <= wr_fstat && reg_wdata[B_RXFLUSH];
            if (eng_done) begin
                ready_q <= 1'b1;
            end else if (wr_xstat && reg_wdata[B_READY]) begin
                ready_q <= 1'b0;
            end
        end
    end

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_tx_q),
        .push  (wr_txd),
        .pop   (tx_pop),
        .wdata (reg_wdata),
        .rdata (tx_head),
        .full  (tx_full),
        .empty (tx_empty)
    );

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk   (clk),
        .rst   (rst),
        .flush (flush_rx_q),
        .push  (rx_push),
        .pop   (rx_pop),
        .wdata (eng_rx),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty)
    );

    spim_shift #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start_q),
        .cpol_idle (cmd_q.mode[1]),
        .mode      (cmd_q.mode),
        .len_m1    (cmd_q.len_m1),
        .tx_word   (eng_tx),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_word   (eng_rx)
    );

    spim_csgen #(.NUM_CS(NUM_CS)) u_cs (
        .sel      (cmd_q.cs_sel),
        .sw_en    (cmd_q.cs_sw),
        .sw_level (cmd_q.cs_val),
        .busy     (eng_busy),
        .cs_n     (cs_n)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CMD:   reg_rdata = cmd_pack(cmd_q);
            OFF_XSTAT: reg_rdata[B_READY] = ready_q;
            OFF_FSTAT: begin
                reg_rdata[B_RXFLUSH]       = flush_rx_q;
                reg_rdata[B_TXFLUSH]       = flush_tx_q;
                reg_rdata[B_ERR]           = |err_q;
                reg_rdata[B_TXOVF:B_RXUNR] = err_q;
                reg_rdata[3:0]             = {tx_full, tx_empty, rx_full, rx_empty};
            end
            OFF_RXD:   reg_rdata = rx_empty ? '0 : rx_head;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spim_chk.sv
module spim_chk
    import spim_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sclk,
    input logic              busy,
    input logic              done,
    input logic              ready,
    input logic              cmd_cpol,
    input logic              start_q,
    input logic              tx_full,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              rx_empty,
    input logic              tx_ovf,
    input logic              reg_wr,
    input logic [8:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [NUM_CS-1:0] cs_n
);
    // R4: never more than one chip select low
    a_r4_cs_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R6: a finished word raises the ready flag
    a_r6_ready_on_done: assert property (@(posedge clk) disable iff (rst)
        done |=> ready);

    // R3: an idle engine holds the clock at the programmed polarity
    a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
        !$past(busy) |-> (sclk == $past(cmd_cpol)));

    // R13: the engine only begins on an accepted start request
    a_r13_start_gate: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_q));

    // R8: overflow stays set unless software writes 1 to its bit
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(tx_ovf) && !($past(reg_wr) && ($past(reg_addr) == OFF_FSTAT)
                            && $past(reg_wdata[B_TXOVF]))) |-> tx_ovf);

    // R14: a FIFO is never both full and empty
    a_r14_flag_excl: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

endmodule

bind spi_word_master spim_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .busy      (eng_busy),
    .done      (eng_done),
    .ready     (ready_q),
    .cmd_cpol  (cmd_q.mode[1]),
    .start_q   (start_q),
    .tx_full   (tx_full),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full),
    .rx_empty  (rx_empty),
    .tx_ovf    (err_q.tx_ovf),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cs_n      (cs_n)
);

// File: tb/sim_spi_word_master.sv
module sim_spi_word_master;
    localparam int CLK_P = 10;
    localparam logic [8:0] A_CMD = 9'h000, A_XST = 9'h010, A_FST = 9'h014,
                           A_TXD = 9'h108, A_RXD = 9'h188;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;

    // sniffer state
    logic        sniff_en = 1'b0;
    logic        cpol_t = 1'b0, cpha_t = 1'b0;
    int          sel_t = 0;
    int          edges = 0;
    logic [31:0] got = '0;
    logic        cs_bad = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    assign miso = mosi;

    spi_word_master u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always @(sclk) begin
        if (sniff_en) begin
            edges++;
            if ((sclk != cpol_t) ^ cpha_t) got = {got[30:0], mosi};
            if ((sclk != cpol_t) && cs_n[sel_t] !== 1'b0) cs_bad = 1'b1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic do_xfer(input int mode, input int lm1, input logic [31:0] word,
                           input bit rxen, input bit txen, input int sel,
                           input bit load, input bit rdrx);
        logic [31:0] cmdv, rdv, msk, exp_tx;
        bit rdy;
        int n;
        n = lm1 + 1;
        msk = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
        exp_tx = (load && txen) ? (word & msk) : 32'd0;
        cmdv = 32'h4000_0000 | (32'(mode) << 28) | (32'(sel) << 26)
             | (32'(rxen) << 12) | (32'(txen) << 11) | 32'(lm1);
        bus_wr(A_CMD, cmdv);
        if (load) bus_wr(A_TXD, word);
        repeat (3) @(posedge clk);
        cpol_t = mode[1]; cpha_t = mode[0]; sel_t = sel;
        got = '0; edges = 0; cs_bad = 1'b0; sniff_en = 1'b1;
        bus_wr(A_CMD, cmdv | 32'h8000_0000);
        rdy = 1'b0;
        rdv = '0;
        for (int p = 0; p < 2000 && !rdy; p++) begin
            bus_rd(A_XST, rdv);
            rdy = rdv[30];
        end
        sniff_en = 1'b0;
        check("R6 ready after word", 32'(rdy), 32'd1);
        check("R2 bits shifted MSB first", got, exp_tx);
        check("R2 edge count", 32'(edges), 32'(2 * n));
        check("R3 idle clock level", 32'(sclk), 32'(mode[1]));
        check("R4 chip select low on leading edges", 32'(cs_bad), 32'd0);
        if (rdrx) begin
            bus_rd(A_RXD, rdv);
            check("R11 received word", rdv, exp_tx);
        end
        bus_wr(A_XST, 32'h4000_0000);
    endtask

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // reset state
        bus_rd(A_CMD, v);  check("R1 reset command", v, 32'h0);
        bus_rd(A_XST, v);  check("R6 reset ready", v, 32'h0);
        bus_rd(A_FST, v);  check("R14 reset fifo status", v, 32'h0000_0005);
        check("R4 reset chip selects", 32'(cs_n), 32'hF);
        check("R3 reset clock", 32'(sclk), 32'd0);

        // near-exhaustive sweep: every mode, every length
        for (int m = 0; m < 4; m++) begin
            for (int l = 0; l < 32; l++) begin
                do_xfer(m, l, (32'h9E37_79B9 * 32'(l + 1)) ^ (32'(m) * 32'h1111_0000),
                        1'b1, 1'b1, l % 4, 1'b1, 1'b1);
            end
        end
        bus_rd(A_XST, v);  check("R6 ready cleared by write one", v, 32'h0);

        // TX overflow, full flag, write-back clear, flush
        for (int i = 0; i < 5; i++) bus_wr(A_TXD, 32'(i));
        bus_rd(A_FST, v);  check("R8 tx overflow with full", v, 32'h0000_0189);
        bus_wr(A_FST, v);
        bus_rd(A_FST, v);  check("R12 write-back clears errors", v, 32'h0000_0009);
        bus_wr(A_FST, 32'h0000_4000);
        bus_rd(A_FST, v);  check("R7 tx flush reads one", v, 32'h0000_4009);
        bus_rd(A_FST, v);  check("R7 tx flush done", v, 32'h0000_0005);

        // start while busy is ignored
        bus_wr(A_TXD, 32'hCAFE_0001);
        bus_wr(A_TXD, 32'hCAFE_0002);
        bus_wr(A_CMD, 32'h4000_081F);
        repeat (3) @(posedge clk);
        bus_wr(A_CMD, 32'hC000_081F);
        repeat (10) @(posedge clk);
        bus_wr(A_CMD, 32'hC000_081F);
        begin
            bit rdy;
            rdy = 1'b0;
            for (int p = 0; p < 2000 && !rdy; p++) begin
                bus_rd(A_XST, v);
                rdy = v[30];
            end
        end
        bus_rd(A_FST, v);  check("R13 busy start pops nothing", v, 32'h0000_0001);
        bus_rd(A_CMD, v);  check("R1 command readback start reads 0", v, 32'h4000_081F);
        bus_wr(A_XST, 32'h4000_0000);
        bus_wr(A_FST, 32'h0000_4000);
        repeat (2) @(posedge clk);

        // TX underrun shifts zeros
        do_xfer(0, 7, 32'h0, 1'b1, 1'b1, 0, 1'b0, 1'b1);
        bus_rd(A_FST, v);  check("R9 tx underrun flag", v, 32'h0000_0145);
        bus_wr(A_FST, v);

        // receive disabled pushes nothing
        do_xfer(1, 15, 32'h0000_BEEF, 1'b0, 1'b1, 1, 1'b1, 1'b0);
        bus_rd(A_FST, v);  check("R11 no push with receive off", v, 32'h0000_0005);

        // RX underrun, summary bit persistence
        bus_rd(A_RXD, v);  check("R10 empty read returns 0", v, 32'h0);
        for (int i = 0; i < 5; i++) bus_wr(A_TXD, 32'(i));
        bus_rd(A_FST, v);  check("R10 rx underrun with tx overflow", v, 32'h0000_0199);
        bus_wr(A_FST, 32'h0000_0080);
        bus_rd(A_FST, v);  check("R12 summary held by remaining flag", v, 32'h0000_0119);
        bus_wr(A_FST, 32'h0000_0010);
        bus_rd(A_FST, v);  check("R12 summary clears", v, 32'h0000_0009);
        bus_wr(A_FST, 32'h0000_4000);
        repeat (2) @(posedge clk);

        // RX overflow keeps the first four words
        for (int i = 1; i <= 5; i++) do_xfer(2, 7, 32'(i * 32'h11), 1'b1, 1'b1, 2, 1'b1, 1'b0);
        bus_rd(A_FST, v);  check("R11 rx overflow with full", v, 32'h0000_0126);
        for (int i = 1; i <= 4; i++) begin
            bus_rd(A_RXD, v);  check("R11 rx fifo order", v, 32'(i * 32'h11));
        end
        bus_rd(A_FST, v);  check("R14 rx drained", v, 32'h0000_0125);
        bus_wr(A_FST, v);
        bus_wr(A_TXD, 32'h1);
        bus_wr(A_FST, 32'h0000_8000);
        bus_rd(A_FST, v);  check("R7 rx flush reads one", v, 32'h0000_8001);

        // software chip select
        bus_wr(A_CMD, 32'h4820_0000);
        @(negedge clk); check("R5 software select low", 32'(cs_n), 32'hB);
        bus_wr(A_CMD, 32'h4830_0000);
        @(negedge clk); check("R5 software select released", 32'(cs_n), 32'hF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule